// File: doc/BRIEF.md
# Protection Fault Error Code Generator

This unit sits behind a segment protection checker and turns one cycle of violation flags into a general protection fault request. It always reports vector 13, and it forms the 16-bit error code that the fault sequencer pushes. Some violation classes push an all-zero code. The others push a code built from the failing selector index, the table the selector came from, and whether the fault arose while an external event was being serviced. In real mode the protection classes do not apply. The unit instead watches for a 16-bit access at the last offset of a segment, which would wrap, and raises the same vector for it.

A request is presented for one cycle on `req_valid`. The fault it produces is registered and held on the outputs until the consumer pulses `flt_ack`. Requests that arrive while a fault is pending and not being acknowledged are dropped. The fault sequencer, descriptor fetch, privilege arithmetic and stack pushes all live elsewhere.

Top module: `gpf_fault_coder`

## Requirements
- R1: After reset `flt_valid` is 0, `flt_code` is 0 and `flt_vector` is 0.
- R2: `flt_vector` reads 13 whenever `flt_valid` is 1, and reads 0 when no fault is pending.
- R3: In protected mode (`real_mode`=0), a request with any `zero_viol` bit set raises a fault on the next cycle with `flt_code` equal to 0. The bits are: bit 0 limit violation, bit 1 write to a read-only segment, bit 2 null or more-privileged data segment access.
- R4: In protected mode, a request with only `sel_viol` bits set raises a fault whose `flt_code[15:3]` equals `sel_index`. Its bit 1 is 1 when `tbl_src[1]`=1 (interrupt table, encodings 2'b10 and 2'b11). Its bit 2 is 1 only for `tbl_src`=2'b01 (local table) and is 0 for 2'b00 (global table) and for the interrupt table.
- R5: When `zero_viol` and `sel_viol` bits are set together, the zero-code result of R3 wins.
- R6: For a selector-bearing fault, `flt_code[0]` equals `ext_evt`.
- R7: In real mode, a request with `acc_word`=1 and `acc_offset`=16'hFFFF raises a fault with `flt_code` 0.
- R8: In real mode, a byte access (`acc_word`=0) at 16'hFFFF, a word access at any other offset, and all `zero_viol`/`sel_viol` flags raise no fault.
- R9: In protected mode, a request with no violation flag set raises no fault.
- R10: A pending fault holds `flt_valid` and `flt_code` unchanged until `flt_ack`. Requests that arrive meanwhile without `flt_ack` are dropped, and an `flt_ack` with no faulting request clears `flt_valid` on the next cycle.
- R11: A faulting request in the same cycle as `flt_ack` replaces the pending fault with the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle violation report strobe |
| zero_viol | input | 3 | Zero-code violation classes |
| sel_viol | input | 2 | Selector-bearing violation classes (wrong type, other) |
| sel_index | input | 13 | Index field of the failing selector |
| tbl_src | input | 2 | Table of the selector: 00 global, 01 local, 1x interrupt |
| ext_evt | input | 1 | Fault arose while servicing an external event |
| real_mode | input | 1 | Processor is in real address mode |
| acc_offset | input | 16 | Segment offset of the access |
| acc_word | input | 1 | 1 for a 16-bit access, 0 for a byte |
| flt_ack | input | 1 | Consumer has taken the pending fault |
| flt_valid | output | 1 | A fault is pending |
| flt_vector | output | 8 | Vector number of the pending fault |
| flt_code | output | 16 | Error code to push |

## Verification
The hardest situation to reach from the ports is a request that lands in the very cycle a pending fault is acknowledged. It must replace the held fault instead of being dropped or cleared. The bench first parks a selector fault on the outputs. It then asserts `flt_ack` and a new faulting request on the same falling edge, and checks that the next code is the new one. A second scenario sends a request without acknowledging and checks that the held code is left unchanged.

// File: rtl/gpf_pkg.sv
package gpf_pkg;
   typedef enum logic [1:0] {
      TBL_GLOBAL = 2'b00,
      TBL_LOCAL  = 2'b01,
      TBL_INTR   = 2'b10,
      TBL_INTR_B = 2'b11
   } tbl_src_e;

   localparam int unsigned GPF_VECTOR_NUM = 13;
endpackage

// File: rtl/gpf_wrap_detect.sv
module gpf_wrap_detect #(
   parameter int unsigned OFS_W     = 16,
   parameter bit          CHECK_EN  = 1'b1
) (
   input  logic [OFS_W-1:0] acc_offset,
   input  logic             acc_word,
   output logic             wrap_hit
);
   localparam logic [OFS_W-1:0] LAST_OFS = {OFS_W{1'b1}};

   generate
      if (CHECK_EN) begin : g_check
         assign wrap_hit = acc_word && (acc_offset == LAST_OFS);
      end else begin : g_nocheck
         assign wrap_hit = 1'b0 & acc_word & (&acc_offset);
      end
   endgenerate
endmodule

// File: rtl/gpf_code_build.sv
module gpf_code_build
   import gpf_pkg::*;
#(
   parameter int unsigned SEL_IDX_W = 13,
   parameter int unsigned N_ZERO    = 3,
   parameter int unsigned N_SEL     = 2,
   localparam int unsigned CODE_W   = SEL_IDX_W + 3
) (
   input  logic [N_ZERO-1:0]    zero_viol,
   input  logic [N_SEL-1:0]     sel_viol,
   input  logic [SEL_IDX_W-1:0] sel_index,
   input  logic [1:0]           tbl_src,
   input  logic                 ext_evt,
   input  logic                 real_mode,
   input  logic                 wrap_hit,
   output logic                 hit,
   output logic [CODE_W-1:0]    code
);
   tbl_src_e src;
   logic     zero_any;
   logic     sel_any;
   logic     in_intr;
   logic     in_local;

   always_comb begin
      src      = tbl_src_e'(tbl_src);
      zero_any = |zero_viol;
      sel_any  = |sel_viol;
      in_intr  = (src == TBL_INTR) || (src == TBL_INTR_B);
      in_local = (src == TBL_LOCAL);

      if (real_mode) begin
         hit  = wrap_hit;
         code = '0;
      end else if (zero_any) begin
         hit  = 1'b1;
         code = '0;
      end else if (sel_any) begin
         hit  = 1'b1;
         code = {sel_index, in_local, in_intr, ext_evt};
      end else begin
         hit  = 1'b0;
         code = '0;
      end
   end
endmodule

// File: rtl/gpf_fault_reg.sv
module gpf_fault_reg #(
   parameter int unsigned CODE_W  = 16,
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned VEC_NUM = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              hit,
   input  logic [CODE_W-1:0] code_in,
   input  logic              flt_ack,
   output logic              flt_valid,
   output logic [VEC_W-1:0]  flt_vector,
   output logic [CODE_W-1:0] flt_code
);
   localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(VEC_NUM);

   logic take;
   assign take = req_valid && hit && (!flt_valid || flt_ack);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_valid  <= 1'b0;
         flt_vector <= '0;
         flt_code   <= '0;
      end else if (take) begin
         flt_valid  <= 1'b1;
         flt_vector <= VEC_VAL;
         flt_code   <= code_in;
      end else if (flt_ack) begin
         flt_valid  <= 1'b0;
         flt_vector <= '0;
         flt_code   <= '0;
      end
   end
endmodule

// File: rtl/gpf_fault_coder.sv
module gpf_fault_coder
   import gpf_pkg::*;
#(
   parameter int unsigned SEL_IDX_W     = 13,
   parameter int unsigned OFS_W         = 16,
   parameter int unsigned VEC_W         = 8,
   parameter int unsigned N_ZERO        = 3,
   parameter int unsigned N_SEL         = 2,
   parameter bit          WRAP_CHECK_EN = 1'b1,
   localparam int unsigned CODE_W       = SEL_IDX_W + 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [N_ZERO-1:0]    zero_viol,
   input  logic [N_SEL-1:0]     sel_viol,
   input  logic [SEL_IDX_W-1:0] sel_index,
   input  logic [1:0]           tbl_src,
   input  logic                 ext_evt,
   input  logic                 real_mode,
   input  logic [OFS_W-1:0]     acc_offset,
   input  logic                 acc_word,
   input  logic                 flt_ack,
   output logic                 flt_valid,
   output logic [VEC_W-1:0]     flt_vector,
   output logic [CODE_W-1:0]    flt_code
);
   initial begin
      assert (OFS_W >= 2) else $error("OFS_W too small");
      assert (VEC_W >= 4) else $error("VEC_W cannot hold the vector");
      assert (N_ZERO >= 1 && N_SEL >= 1) else $error("need violation classes");
   end

   logic              wrap_hit;
   logic              hit;
   logic [CODE_W-1:0] code_c;

   gpf_wrap_detect #(
      .OFS_W    (OFS_W),
      .CHECK_EN (WRAP_CHECK_EN)
   ) u_wrap (
      .acc_offset (acc_offset),
      .acc_word   (acc_word),
      .wrap_hit   (wrap_hit)
   );

   gpf_code_build #(
      .SEL_IDX_W (SEL_IDX_W),
      .N_ZERO    (N_ZERO),
      .N_SEL     (N_SEL)
   ) u_code (
      .zero_viol (zero_viol),
      .sel_viol  (sel_viol),
      .sel_index (sel_index),
      .tbl_src   (tbl_src),
      .ext_evt   (ext_evt),
      .real_mode (real_mode),
      .wrap_hit  (wrap_hit),
      .hit       (hit),
      .code      (code_c)
   );

   gpf_fault_reg #(
      .CODE_W  (CODE_W),
      .VEC_W   (VEC_W),
      .VEC_NUM (GPF_VECTOR_NUM)
   ) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .hit        (hit),
      .code_in    (code_c),
      .flt_ack    (flt_ack),
      .flt_valid  (flt_valid),
      .flt_vector (flt_vector),
      .flt_code   (flt_code)
   );
endmodule

// File: rtl/gpf_fault_checker.sv
module gpf_fault_checker #(
   parameter int unsigned SEL_IDX_W = 13,
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned N_ZERO    = 3,
   localparam int unsigned CODE_W   = SEL_IDX_W + 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [N_ZERO-1:0] zero_viol,
   input logic              real_mode,
   input logic              acc_word,
   input logic              flt_ack,
   input logic              flt_valid,
   input logic [VEC_W-1:0]  flt_vector,
   input logic [CODE_W-1:0] flt_code
);
   logic can_take;
   assign can_take = req_valid && (!flt_valid || flt_ack);

   assert_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid |-> (flt_vector == VEC_W'(13)));

   assert_zero_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (can_take && !real_mode && (|zero_viol)) |=> (flt_valid && flt_code == '0));

   assert_byte_no_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (can_take && real_mode && !acc_word) |=> !flt_valid);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && !flt_ack) |=> (flt_valid && $stable(flt_code)));

   assert_ack_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && flt_ack && !req_valid) |=> !flt_valid);
endmodule

bind gpf_fault_coder gpf_fault_checker #(
   .SEL_IDX_W (SEL_IDX_W),
   .VEC_W     (VEC_W),
   .N_ZERO    (N_ZERO)
) u_gpf_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .zero_viol  (zero_viol),
   .real_mode  (real_mode),
   .acc_word   (acc_word),
   .flt_ack    (flt_ack),
   .flt_valid  (flt_valid),
   .flt_vector (flt_vector),
   .flt_code   (flt_code)
);

// File: tb/gpf_fault_coder_test.sv
`timescale 1ns/1ps
module gpf_fault_coder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  zero_viol = '0;
   logic [1:0]  sel_viol = '0;
   logic [12:0] sel_index = '0;
   logic [1:0]  tbl_src = '0;
   logic        ext_evt = 1'b0;
   logic        real_mode = 1'b0;
   logic [15:0] acc_offset = '0;
   logic        acc_word = 1'b0;
   logic        flt_ack = 1'b0;
   logic        flt_valid;
   logic [7:0]  flt_vector;
   logic [15:0] flt_code;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   gpf_fault_coder uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .zero_viol(zero_viol),
      .sel_viol(sel_viol), .sel_index(sel_index), .tbl_src(tbl_src),
      .ext_evt(ext_evt), .real_mode(real_mode), .acc_offset(acc_offset),
      .acc_word(acc_word), .flt_ack(flt_ack), .flt_valid(flt_valid),
      .flt_vector(flt_vector), .flt_code(flt_code)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] sel_code(input logic [12:0] idx, input logic [1:0] src,
                                            input logic ext);
      logic idt, ldt;
      idt = (src == 2'b10) || (src == 2'b11);
      ldt = (src == 2'b01);
      return {idx, ldt, idt, ext};
   endfunction

   task automatic clear_inputs();
      req_valid = 0; zero_viol = '0; sel_viol = '0; sel_index = '0; tbl_src = '0;
      ext_evt = 0; real_mode = 0; acc_offset = '0; acc_word = 0; flt_ack = 0;
   endtask

   // one request cycle: drive at negedge, result visible after the posedge
   task automatic send(input logic [2:0] zv, input logic [1:0] sv, input logic [12:0] idx,
                       input logic [1:0] src, input logic ext, input logic rm,
                       input logic [15:0] ofs, input logic wd, input logic ack);
      @(negedge clk);
      req_valid = 1; zero_viol = zv; sel_viol = sv; sel_index = idx; tbl_src = src;
      ext_evt = ext; real_mode = rm; acc_offset = ofs; acc_word = wd; flt_ack = ack;
      @(posedge clk); #1;
      clear_inputs();
   endtask

   task automatic ack_pulse();
      @(negedge clk); flt_ack = 1;
      @(posedge clk); #1; flt_ack = 0;
   endtask

   task automatic t_reset();
      check("R1 valid", flt_valid, 0);
      check("R1 code", flt_code, 0);
      check("R1 vector", flt_vector, 0);
      check("R2 idle vector", flt_vector, 0);
   endtask

   task automatic t_zero_classes();
      for (int b = 0; b < 3; b++) begin
         send(3'b1 << b, 2'b00, 13'h1234, 2'b01, 1, 0, 16'h0, 0, 0);
         check("R3 valid", flt_valid, 1);
         check("R3 code", flt_code, 0);
         check("R2 vector", flt_vector, 13);
         ack_pulse();
         check("R10 ack clears", flt_valid, 0);
      end
   endtask

   task automatic t_selector();
      logic [12:0] idx [4] = '{13'h0001, 13'h1ABC, 13'h1FFF, 13'h0555};
      for (int s = 0; s < 4; s++) begin
         send(3'b000, 2'b01, idx[s], 2'(s), 0, 0, 16'h0, 0, 0);
         check("R4 valid", flt_valid, 1);
         check("R4 code", flt_code, sel_code(idx[s], 2'(s), 0));
         ack_pulse();
      end
      send(3'b000, 2'b10, 13'h0F0F, 2'b01, 1, 0, 16'h0, 0, 0);
      check("R6 ext bit code", flt_code, sel_code(13'h0F0F, 2'b01, 1));
      ack_pulse();
   endtask

   task automatic t_priority();
      send(3'b010, 2'b11, 13'h1111, 2'b10, 1, 0, 16'h0, 0, 0);
      check("R5 valid", flt_valid, 1);
      check("R5 code", flt_code, 0);
      ack_pulse();
   endtask

   task automatic t_real_mode();
      send(3'b000, 2'b00, 13'h0, 2'b00, 0, 1, 16'hFFFF, 1, 0);
      check("R7 valid", flt_valid, 1);
      check("R7 code", flt_code, 0);
      check("R7 vector", flt_vector, 13);
      ack_pulse();
      send(3'b000, 2'b00, 13'h0, 2'b00, 0, 1, 16'hFFFF, 0, 0);
      check("R8 byte at FFFF", flt_valid, 0);
      send(3'b000, 2'b00, 13'h0, 2'b00, 0, 1, 16'hFFFE, 1, 0);
      check("R8 word at FFFE", flt_valid, 0);
      send(3'b111, 2'b11, 13'h0AAA, 2'b01, 1, 1, 16'h0010, 1, 0);
      check("R8 flags ignored", flt_valid, 0);
      check("R2 vector idle", flt_vector, 0);
   endtask

   task automatic t_no_flags();
      send(3'b000, 2'b00, 13'h0777, 2'b01, 1, 0, 16'hFFFF, 1, 0);
      check("R9 no fault", flt_valid, 0);
   endtask

   task automatic t_hold_and_replace();
      send(3'b000, 2'b01, 13'h0123, 2'b00, 0, 0, 16'h0, 0, 0);
      check("R10 first", flt_code, sel_code(13'h0123, 2'b00, 0));
      send(3'b000, 2'b01, 13'h0456, 2'b01, 1, 0, 16'h0, 0, 0);
      check("R10 held valid", flt_valid, 1);
      check("R10 dropped", flt_code, sel_code(13'h0123, 2'b00, 0));
      @(posedge clk); #1;
      check("R10 still held", flt_code, sel_code(13'h0123, 2'b00, 0));
      send(3'b000, 2'b01, 13'h0789, 2'b10, 1, 0, 16'h0, 0, 1);
      check("R11 valid", flt_valid, 1);
      check("R11 replaced", flt_code, sel_code(13'h0789, 2'b10, 1));
      ack_pulse();
      check("R10 cleared", flt_valid, 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #1;
      t_reset();
      repeat (2) @(posedge clk);
      #1; rst_n = 1;
      t_reset();
      t_zero_classes();
      t_selector();
      t_priority();
      t_real_mode();
      t_no_flags();
      t_hold_and_replace();
      repeat (2) @(posedge clk);
      finish_run();
   end

   initial begin
      #100000;
      checks++; failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end
endmodule